// File: doc/BRIEF.md
# Interconnect Fault Diagnosis Sequencer

This block steps a tester through the series of test configurations that locates a single fault among `NUM_NETS` numbered nets. For every step it presents a descriptor: the kind of configuration and the 0/1 value that each net must carry. It then waits for one pass/fail pulse from the environment, which loads the configuration and applies it. The block turns the pass/fail outcomes into a verdict. The verdict is either no fault, a stuck-at-0, stuck-at-1 or open net together with its index, or a short between two nets together with both indices.

The run always begins with a counting phase. In that phase every net is given a distinct binary code, and the failing steps spell out the code of the faulty net. If diagnosis is enabled, two uniform steps follow: one with every net low, then one with every net high. Their two outcomes select the fault class. When both uniform steps pass, the fault is a short. The block then runs an adaptive search over the net indices, and each step of that search depends on the outcome of the step before it.

Top module: `net_diag_seq`

## Requirements
- R1: Right after reset `busy`, `cfg_valid` and `done` are low, `fault_class` is 0 (no fault), and `net_a` and `net_b` are 0.
- R2: After `start` is accepted, the block issues CW = ceil(log2(NUM_NETS+2)) descriptors of kind 0 (counting). In the k-th of these, counting k from 0, net i is driven to bit k of the value i+1.
- R3: If every counting step passes, the run ends with class 0 and both indices 0, and no further descriptor is issued.
- R4: When `diag_en` is low at `start` and at least one counting step fails, the run ends after the counting steps with class 5 (detected, unclassified). Here `net_a` = (P-1) mod 2^IW, where IW = ceil(log2(NUM_NETS)) and bit k of P is the outcome of counting step k (1 = fail).
- R5: When `diag_en` is high at `start` and P is non-zero, the next descriptor is kind 1 with every net 0, followed by kind 2 with every net 1.
- R6: Let Z be the outcome of the kind-1 step and O the outcome of the kind-2 step. (Z,O)=(0,1) reports class 1 (stuck-at-0) with `net_a`=P-1. (1,0) reports class 2 (stuck-at-1) with `net_a`=((~P) mod 2^CW)-1. (1,1) reports class 3 (open) with `net_a`=P-1. In each of these cases `net_b` is 0.
- R7: (Z,O)=(0,0) starts the short search with descriptors of kind 3. In the first of these, net i is driven to bit IW-1 of i, so the lower half of the index range is 0 and the upper half is 1. For a short between nets a<b, exactly 2*IW-1 kind-3 steps are issued, and the run reports class 4 with `net_a`=a and `net_b`=b. If every split step passes, the run reports class 0.
- R8: While `cfg_valid` is high and `cfg_ready` is low, the descriptor holds steady. After a handshake, `cfg_valid` stays low until a result pulse arrives. The next descriptor appears in the cycle after that pulse.
- R9: `done` is a one-cycle pulse in the cycle after the final result pulse, and `busy` is low in that same cycle. Class and indices then hold until the next accepted `start`.
- R10: A `res_valid` pulse that arrives while no descriptor is outstanding has no effect, and neither does a `start` while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (taken only when idle) |
| diag_en | input | 1 | Classify and locate after a failing count phase |
| cfg_valid | output | 1 | Descriptor offered |
| cfg_ready | input | 1 | Descriptor taken by the environment |
| cfg_kind | output | 2 | 0 counting, 1 all-low, 2 all-high, 3 split |
| cfg_nets | output | NUM_NETS | Value each net must carry |
| res_valid | input | 1 | One-cycle pulse carrying a step outcome |
| res_fail | input | 1 | Outcome: 1 = step failed |
| done | output | 1 | One-cycle pulse at the end of a run |
| busy | output | 1 | Run in progress |
| fault_class | output | 3 | 0 none, 1 SA0, 2 SA1, 3 open, 4 short, 5 detected |
| net_a | output | ceil(log2 NUM_NETS) | Faulty net, or lower net of a short |
| net_b | output | ceil(log2 NUM_NETS) | Upper net of a short, else 0 |

## Verification
A descriptor becomes visible one cycle after the `start` edge that accepted it, or one cycle after the result pulse that closed the previous step. The verdict and `done` become visible one cycle after the final result pulse. The bench drives all inputs on falling edges and samples all outputs on falling edges, so each value it reads was registered at the rising edge just before. The bench plays the faulty fabric itself. It computes each step's outcome from the fault it injected, and it compares the verdict, the step count and the early descriptors against values derived from that fault. It holds `cfg_ready` low at random and inserts random delays before each result, and in those gaps it checks that the descriptor holds and that stray pulses do nothing.

// File: rtl/net_diag_pkg.sv
package net_diag_pkg;
  typedef enum logic [1:0] {
    K_COUNT = 2'd0,
    K_ZEROS = 2'd1,
    K_ONES  = 2'd2,
    K_SPLIT = 2'd3
  } cfg_kind_e;

  typedef enum logic [2:0] {
    FC_NONE   = 3'd0,
    FC_SA0    = 3'd1,
    FC_SA1    = 3'd2,
    FC_OPEN   = 3'd3,
    FC_BRIDGE = 3'd4,
    FC_DETECT = 3'd5
  } fault_class_e;

  typedef enum logic [2:0] {
    PH_COUNT,
    PH_ZEROS,
    PH_ONES,
    PH_SPLIT,
    PH_HUNT_LO,
    PH_HUNT_HI
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/net_diag_pattern.sv
// Builds the per-net drive values for the current step.
module net_diag_pattern import net_diag_pkg::*; #(
  parameter int NUM_NETS = 8,
  parameter int IW = 3,
  parameter int CW = 4,
  parameter int PW = 4
) (
  input  phase_e                   phase,
  input  logic signed [PW-1:0]     pos,
  input  logic [IW-1:0]            split_bit,
  output logic [1:0]               kind,
  output logic [NUM_NETS-1:0]      nets
);

  // bit p of v, 0 when p is out of range
  function automatic logic pick(input logic [CW-1:0] v, input int p);
    logic r;
    r = 1'b0;
    for (int k = 0; k < CW; k++) if (p == k) r = v[k];
    return r;
  endfunction

  always_comb begin
    unique case (phase)
      PH_COUNT: kind = K_COUNT;
      PH_ZEROS: kind = K_ZEROS;
      PH_ONES:  kind = K_ONES;
      default:  kind = K_SPLIT;
    endcase
  end

  for (genvar gi = 0; gi < NUM_NETS; gi++) begin : g_net
    localparam logic [CW-1:0] CODE = CW'(gi + 1);
    localparam logic [CW-1:0] IDXW = CW'(gi);
    localparam logic [IW-1:0] IDX  = IW'(gi);
    logic on_d, on_p, val;
    always_comb begin
      on_d = IDX[split_bit];
      on_p = pick(IDXW, int'(pos));
      unique case (phase)
        PH_COUNT:   val = pick(CODE, int'(pos));
        PH_ZEROS:   val = 1'b0;
        PH_ONES:    val = 1'b1;
        PH_SPLIT:   val = on_p;
        PH_HUNT_LO: val = on_d | on_p;   // low only where bit d and bit p are both 0
        PH_HUNT_HI: val = on_d & ~on_p;  // high only where bit d is 1 and bit p is 0
        default:    val = 1'b0;
      endcase
    end
    assign nets[gi] = val;
  end

endmodule

// File: rtl/net_diag_decode.sv
// Turns the counting pattern and the two uniform outcomes into a verdict.
module net_diag_decode import net_diag_pkg::*; #(
  parameter int IW = 3,
  parameter int CW = 4
) (
  input  logic [CW-1:0] pat,
  input  logic          zeros_fail,
  input  logic          ones_fail,
  output fault_class_e  cls,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] det_idx,
  output logic          need_hunt
);

  function automatic logic [IW-1:0] code_to_idx(input logic [CW-1:0] code);
    return IW'(code - CW'(1));
  endfunction

  assign det_idx = code_to_idx(pat);

  always_comb begin
    need_hunt = 1'b0;
    unique case ({zeros_fail, ones_fail})
      2'b01: begin cls = FC_SA0;  idx = code_to_idx(pat);  end
      2'b10: begin cls = FC_SA1;  idx = code_to_idx(~pat); end
      2'b11: begin cls = FC_OPEN; idx = code_to_idx(pat);  end
      default: begin cls = FC_BRIDGE; idx = '0; need_hunt = 1'b1; end
    endcase
  end

endmodule

// File: rtl/net_diag_seq.sv
module net_diag_seq import net_diag_pkg::*; #(
  parameter int NUM_NETS = 8,
  localparam int IW = $clog2(NUM_NETS),
  localparam int CW = $clog2(NUM_NETS + 2),
  localparam int PW = $clog2(CW + 1) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                diag_en,
  output logic                cfg_valid,
  input  logic                cfg_ready,
  output logic [1:0]          cfg_kind,
  output logic [NUM_NETS-1:0] cfg_nets,
  input  logic                res_valid,
  input  logic                res_fail,
  output logic                done,
  output logic                busy,
  output logic [2:0]          fault_class,
  output logic [IW-1:0]       net_a,
  output logic [IW-1:0]       net_b
);

  seq_state_e st_q, st_d;
  phase_e phase_q, phase_d;
  logic signed [PW-1:0] pos_q, pos_d;
  logic [IW-1:0] d_q, d_d, a_q, a_d, b_q, b_d, na_q, na_d, nb_q, nb_d;
  logic [CW-1:0] pat_q, pat_d, pat_nx;
  logic [IW-1:0] a_nx, b_nx;
  logic zeros_q, zeros_d, diag_q, diag_d, done_q, done_d;
  fault_class_e cls_q, cls_d;

  // named events for the checker
  logic start_take, desc_fire, res_take, finish_now;

  fault_class_e dec_cls;
  logic [IW-1:0] dec_idx, det_idx;
  logic dec_hunt;

  // next bit to probe below cur, stepping over the split bit
  function automatic int next_lo(input int cur, input int d);
    int n;
    n = cur - 1;
    if (n == d) n = n - 1;
    return n;
  endfunction

  function automatic logic [IW-1:0] lo_net(input logic [IW-1:0] a, input logic [IW-1:0] d);
    logic [IW-1:0] r;
    r = a;
    r[d] = 1'b0;
    return r;
  endfunction

  function automatic logic [IW-1:0] hi_net(input logic [IW-1:0] a, input logic [IW-1:0] b,
                                           input logic [IW-1:0] d);
    logic [IW-1:0] r;
    for (int k = 0; k < IW; k++) begin
      if (k > int'(d))       r[k] = a[k];
      else if (k == int'(d)) r[k] = 1'b1;
      else                   r[k] = b[k];
    end
    return r;
  endfunction

  net_diag_pattern #(.NUM_NETS(NUM_NETS), .IW(IW), .CW(CW), .PW(PW)) u_pat (
    .phase     (phase_q),
    .pos       (pos_q),
    .split_bit (d_q),
    .kind      (cfg_kind),
    .nets      (cfg_nets)
  );

  net_diag_decode #(.IW(IW), .CW(CW)) u_dec (
    .pat        (pat_nx),
    .zeros_fail (zeros_q),
    .ones_fail  (res_fail),
    .cls        (dec_cls),
    .idx        (dec_idx),
    .det_idx    (det_idx),
    .need_hunt  (dec_hunt)
  );

  assign start_take = (st_q == ST_IDLE) && start;
  assign desc_fire  = (st_q == ST_ISSUE) && cfg_ready;
  assign res_take   = (st_q == ST_WAIT) && res_valid;

  // outcome folded into the pattern / search bits of this step
  always_comb begin
    pat_nx = pat_q;
    a_nx   = a_q;
    b_nx   = b_q;
    for (int k = 0; k < CW; k++)
      if (phase_q == PH_COUNT && int'(pos_q) == k && res_fail) pat_nx[k] = 1'b1;
    for (int k = 0; k < IW; k++) begin
      if (phase_q == PH_HUNT_LO && int'(pos_q) == k) a_nx[k] = ~res_fail;
      if (phase_q == PH_HUNT_HI && int'(pos_q) == k) b_nx[k] = ~res_fail;
    end
  end

  always_comb begin : p_next
    logic fin;
    fault_class_e fcls;
    logic [IW-1:0] fa, fb, dn;
    int nl;
    st_d = st_q;   phase_d = phase_q; pos_d = pos_q; d_d = d_q;
    a_d = a_q;     b_d = b_q;         pat_d = pat_q; zeros_d = zeros_q;
    diag_d = diag_q; cls_d = cls_q;   na_d = na_q;   nb_d = nb_q;
    done_d = 1'b0;
    fin = 1'b0; fcls = FC_NONE; fa = '0; fb = '0; dn = '0; nl = 0;

    if (start_take) begin
      st_d = ST_ISSUE; phase_d = PH_COUNT; pos_d = '0; d_d = '0;
      a_d = '0; b_d = '0; pat_d = '0; zeros_d = 1'b0; diag_d = diag_en;
      cls_d = FC_NONE; na_d = '0; nb_d = '0;
    end else if (desc_fire) begin
      st_d = ST_WAIT;
    end else if (res_take) begin
      st_d = ST_ISSUE;
      unique case (phase_q)
        PH_COUNT: begin
          pat_d = pat_nx;
          if (int'(pos_q) == CW - 1) begin
            if (pat_nx == '0) fin = 1'b1;
            else if (!diag_q) begin fin = 1'b1; fcls = FC_DETECT; fa = det_idx; end
            else phase_d = PH_ZEROS;
          end else pos_d = pos_q + PW'(1);
        end
        PH_ZEROS: begin
          zeros_d = res_fail;
          phase_d = PH_ONES;
        end
        PH_ONES: begin
          if (dec_hunt) begin phase_d = PH_SPLIT; pos_d = PW'(IW - 1); end
          else begin fin = 1'b1; fcls = dec_cls; fa = dec_idx; end
        end
        PH_SPLIT: begin
          if (res_fail) begin
            dn  = IW'(pos_q);
            d_d = dn;
            nl  = next_lo(IW, int'(dn));
            if (nl >= 0) begin phase_d = PH_HUNT_LO; pos_d = PW'(nl); end
            else if (dn != '0) begin phase_d = PH_HUNT_HI; pos_d = PW'(int'(dn) - 1); end
            else begin
              fin = 1'b1; fcls = FC_BRIDGE;
              fa = lo_net(a_q, dn); fb = hi_net(a_q, b_q, dn);
            end
          end else if (pos_q == '0) fin = 1'b1;
          else pos_d = pos_q - PW'(1);
        end
        PH_HUNT_LO: begin
          a_d = a_nx;
          nl  = next_lo(int'(pos_q), int'(d_q));
          if (nl >= 0) pos_d = PW'(nl);
          else if (d_q != '0) begin phase_d = PH_HUNT_HI; pos_d = PW'(int'(d_q) - 1); end
          else begin
            fin = 1'b1; fcls = FC_BRIDGE;
            fa = lo_net(a_nx, d_q); fb = hi_net(a_nx, b_q, d_q);
          end
        end
        PH_HUNT_HI: begin
          b_d = b_nx;
          if (pos_q != '0) pos_d = pos_q - PW'(1);
          else begin
            fin = 1'b1; fcls = FC_BRIDGE;
            fa = lo_net(a_q, d_q); fb = hi_net(a_q, b_nx, d_q);
          end
        end
        default: fin = 1'b1;
      endcase
      if (fin) begin
        st_d = ST_IDLE; done_d = 1'b1; cls_d = fcls; na_d = fa; nb_d = fb;
      end
    end
    finish_now = fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  phase_q <= PH_COUNT; pos_q <= '0; d_q <= '0;
      a_q <= '0;        b_q <= '0;           pat_q <= '0; zeros_q <= 1'b0;
      diag_q <= 1'b0;   cls_q <= FC_NONE;    na_q <= '0;  nb_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q <= st_d;     phase_q <= phase_d;  pos_q <= pos_d; d_q <= d_d;
      a_q <= a_d;       b_q <= b_d;          pat_q <= pat_d; zeros_q <= zeros_d;
      diag_q <= diag_d; cls_q <= cls_d;      na_q <= na_d;   nb_q <= nb_d;
      done_q <= done_d;
    end
  end

  assign cfg_valid   = (st_q == ST_ISSUE);
  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign fault_class = cls_q;
  assign net_a       = na_q;
  assign net_b       = nb_q;

endmodule

// File: rtl/net_diag_seq_chk.sv
module net_diag_seq_chk #(
  parameter int NUM_NETS = 8,
  parameter int IW = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_valid,
  input logic                cfg_ready,
  input logic [1:0]          cfg_kind,
  input logic [NUM_NETS-1:0] cfg_nets,
  input logic                done,
  input logic                busy,
  input logic [2:0]          fault_class,
  input logic [IW-1:0]       net_a,
  input logic [IW-1:0]       net_b,
  input logic                desc_fire,
  input logic                res_take,
  input logic                finish_now
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cfg_valid);

  p_zeros_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_kind == 2'd1) |-> (cfg_nets == '0));

  p_ones_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_kind == 2'd2) |-> (&cfg_nets));

  p_bridge_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_class == 3'd4) |-> (net_a < net_b));

  p_hold_desc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_kind) && $stable(cfg_nets)));

  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_fire |=> !cfg_valid);

  p_next_after_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_take && !finish_now) |=> cfg_valid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !cfg_valid));

  p_finish_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    finish_now |=> done);

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || ($stable(fault_class) && $stable(net_a) && $stable(net_b))));

endmodule

bind net_diag_seq net_diag_seq_chk #(.NUM_NETS(NUM_NETS), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_valid   (cfg_valid),
  .cfg_ready   (cfg_ready),
  .cfg_kind    (cfg_kind),
  .cfg_nets    (cfg_nets),
  .done        (done),
  .busy        (busy),
  .fault_class (fault_class),
  .net_a       (net_a),
  .net_b       (net_b),
  .desc_fire   (desc_fire),
  .res_take    (res_take),
  .finish_now  (finish_now)
);

// File: tb/test_net_diag_seq.sv
module test_net_diag_seq;
  localparam int NN = 8;
  localparam int IW = $clog2(NN);
  localparam int CW = $clog2(NN + 2);
  localparam int F_NONE = 0, F_SA0 = 1, F_SA1 = 2, F_OPEN = 3, F_BRIDGE = 4, F_DET = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, diag_en = 1'b0;
  logic cfg_ready = 1'b0, res_valid = 1'b0, res_fail = 1'b0;
  logic cfg_valid, done, busy;
  logic [1:0] cfg_kind;
  logic [NN-1:0] cfg_nets;
  logic [2:0] fault_class;
  logic [IW-1:0] net_a, net_b;

  int n_chk = 0, n_fail = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  net_diag_seq #(.NUM_NETS(NN)) i_net_diag_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .diag_en(diag_en),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_kind(cfg_kind), .cfg_nets(cfg_nets),
    .res_valid(res_valid), .res_fail(res_fail), .done(done), .busy(busy),
    .fault_class(fault_class), .net_a(net_a), .net_b(net_b)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // net i carries bit k of i+1 in counting step k
  function automatic logic [NN-1:0] count_nets(input int k);
    logic [NN-1:0] v;
    for (int i = 0; i < NN; i++) v[i] = ((i + 1) >> k) & 1;
    return v;
  endfunction

  function automatic logic [NN-1:0] half_nets();
    logic [NN-1:0] v;
    for (int i = 0; i < NN; i++) v[i] = (i >> (IW - 1)) & 1;
    return v;
  endfunction

  // the faulty fabric
  function automatic bit fail_of(input int ft, input int fa, input int fb,
                                 input int kind, input logic [NN-1:0] nets);
    case (ft)
      F_SA0:    return nets[fa];
      F_SA1:    return !nets[fa];
      F_OPEN:   return (kind == 1 || kind == 2) ? 1'b1 : nets[fa];
      F_BRIDGE: return nets[fa] != nets[fb];
      default:  return 1'b0;
    endcase
  endfunction

  function automatic int pattern_of(input int ft, input int fa, input int fb);
    int p;
    p = 0;
    for (int k = 0; k < CW; k++) if (fail_of(ft, fa, fb, 0, count_nets(k))) p |= (1 << k);
    return p;
  endfunction

  task automatic run_case(input int ft, input int fa, input int fb, input bit dg);
    int steps, p, e_cls, e_na, e_nb, e_steps, held;
    logic [1:0] k0;
    logic [NN-1:0] n0;
    bit f;
    string rq;
    @(negedge clk);
    diag_en = dg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    steps = 0;
    while (!done) begin
      if (cfg_valid) begin
        if ($urandom % 4 == 0) begin
          // stall: stray result and stray start must be ignored (R10)
          k0 = cfg_kind; n0 = cfg_nets;
          cfg_ready = 1'b0; res_valid = 1'b1; res_fail = 1'b1; start = 1'b1;
          @(negedge clk);
          res_valid = 1'b0; res_fail = 1'b0; start = 1'b0;
          check("R8", "held valid", cfg_valid, 1);
          check("R8", "held kind", cfg_kind, k0);
          check("R8", "held nets", cfg_nets, n0);
        end else begin
          cfg_ready = 1'b1;
          if (steps < CW) begin
            check("R2", "count kind", cfg_kind, 0);
            check("R2", "count nets", cfg_nets, count_nets(steps));
          end else if (steps == CW) begin
            check("R5", "zeros kind", cfg_kind, 1);
            check("R5", "zeros nets", cfg_nets, 0);
          end else if (steps == CW + 1) begin
            check("R5", "ones kind", cfg_kind, 2);
            check("R5", "ones nets", cfg_nets, {NN{1'b1}});
          end else begin
            check("R7", "split kind", cfg_kind, 3);
            if (steps == CW + 2) check("R7", "first split nets", cfg_nets, half_nets());
          end
          f = fail_of(ft, fa, fb, int'(cfg_kind), cfg_nets);
          steps++;
          @(negedge clk);
          cfg_ready = 1'b0;
          repeat ($urandom % 3) begin
            check("R8", "no valid while outstanding", cfg_valid, 0);
            @(negedge clk);
          end
          res_valid = 1'b1; res_fail = f;
          @(negedge clk);
          res_valid = 1'b0; res_fail = 1'b0;
        end
      end else begin
        check("R8", "descriptor due after result", 0, 1);
        @(negedge clk);
      end
    end

    p = pattern_of(ft, fa, fb);
    e_na = 0; e_nb = 0; e_steps = CW;
    if (p == 0) begin e_cls = F_NONE; rq = "R3"; end
    else if (!dg) begin e_cls = F_DET; e_na = (p - 1) & ((1 << IW) - 1); rq = "R4"; end
    else begin
      e_cls = ft; e_na = fa; e_steps = CW + 2; rq = "R6";
      if (ft == F_BRIDGE) begin e_nb = fb; e_steps = CW + 2 + 2 * IW - 1; rq = "R7"; end
    end
    check(rq, "class", fault_class, e_cls);
    check(rq, "net_a", net_a, e_na);
    check(rq, "net_b", net_b, e_nb);
    check(rq, "step count", steps, e_steps);
    check("R9", "busy at done", busy, 0);
    held = fault_class;
    res_valid = 1'b1; res_fail = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; res_fail = 1'b0;
    check("R9", "done single pulse", done, 0);
    check("R10", "class kept after stray result", fault_class, held);
    check("R10", "no descriptor while idle", cfg_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd5117));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy", busy, 0);
    check("R1", "cfg_valid", cfg_valid, 0);
    check("R1", "done", done, 0);
    check("R1", "class", fault_class, 0);
    check("R1", "net_a", net_a, 0);
    check("R1", "net_b", net_b, 0);

    run_case(F_NONE, 0, 0, 1'b1);
    run_case(F_SA0, 0, 0, 1'b1);
    run_case(F_SA1, NN - 1, 0, 1'b1);
    run_case(F_OPEN, 3, 0, 1'b1);
    run_case(F_BRIDGE, 0, NN - 1, 1'b1);
    run_case(F_BRIDGE, 6, 7, 1'b1);
    run_case(F_BRIDGE, 2, 5, 1'b1);
    run_case(F_BRIDGE, 0, 1, 1'b1);
    run_case(F_SA0, 5, 0, 1'b0);
    run_case(F_SA1, 2, 0, 1'b0);
    run_case(F_BRIDGE, 1, 4, 1'b0);
    run_case(F_NONE, 0, 0, 1'b0);

    for (int it = 0; it < 60; it++) begin
      int ft, a, b, t;
      ft = $urandom % 5;
      a = $urandom % NN;
      b = (a + 1 + ($urandom % (NN - 1))) % NN;
      if (a > b) begin t = a; a = b; b = t; end
      run_case(ft, a, b, ($urandom % 4) != 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    ended = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule